// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Interface

This block is the serial front end of a real-time clock. It holds sixteen 8-bit registers and lets an SPI master read or write them, either one register per chip-select window or as a burst over consecutive addresses. The first byte of every window is a command byte. It names a starting register and an access mode. The bytes that follow carry the data.

The timekeeping core sits on the other side. It sees every register on a flat parallel bus, and it pushes each new time value (registers 0 to 6) through a valid/ready stream. When chip select is raised, the block copies the seven time registers into a shadow. Reads of those addresses are served from the shadow, so a multi-byte read stays coherent even if a seconds carry comes in part way through. An update that arrives while chip select is high is parked in a one-entry hold. It is written into the registers once the window closes. On the update stream, back-pressure works as follows: `upd_time` must stay stable with `upd_valid` high until a cycle in which `upd_ready` is high. `upd_ready` stays low while the hold is occupied, so at most one update waits per window.

The SPI pins are sampled with the system clock through synchronizers, so the serial clock must be several times slower than `clk`.

Top module: `rtc_spi_regif`

## Requirements
- R1: Command byte: bits 7:4 give the register address. Low nibble 0x8 is a single write, 0xC a single read, 0x0 a burst write and 0x4 a burst read. Any other low nibble makes the window write nothing and return zero on MISO.
- R2: Chip select is active high. SCK idles low. The slave changes MISO after each rising SCK edge and samples MOSI on each falling edge. Bytes go most significant bit first.
- R3: A single access moves exactly one data byte. Any later bytes in the same window are ignored: they are not written and they read as zero.
- R4: In burst mode the address advances by one after each data byte and wraps from 15 to 0.
- R5: MISO is zero while chip select is low, during the command byte and during write data bytes.
- R6: Reads of addresses 0–6 return the values those registers held when chip select was raised.
- R7: `upd_ready` is high exactly when no update is held. An update accepted while chip select is high is held. It is written so that byte i of `upd_time` (bits 8i+7:8i) lands in address i after chip select falls.
- R8: An SPI write to any address 0–6 discards a held update.
- R9: After reset, every register is zero except address 15, which is 0x10. `upd_ready` is 1 and MISO is 0. `regs_o` bits 8i+7:8i show address i.
- R10: A pulse on `osc_fail` sets bit 4 of address 15, and writing 0x00 there clears it. Address 13 always reads zero and ignores writes.
- R11: `mode_24h` follows bit 5 of address 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs | input | 1 | Chip select, active high |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| upd_valid | input | 1 | Core offers a new time value |
| upd_ready | output | 1 | Hold is free to take an update |
| upd_time | input | 56 | Time bytes for addresses 0–6, byte i at bits 8i+7:8i |
| osc_fail | input | 1 | Pulse that raises the oscillator-stopped flag |
| regs_o | output | 128 | All registers, address i at bits 8i+7:8i |
| mode_24h | output | 1 | 24-hour mode flag |

## Verification
A corrupted bit counter or a wrong command state shows up on MISO within the same window: bits move into the wrong byte, or data appears during the command byte. A wrong address counter shows up within one data byte, either as a wrong read byte or as a write landing on the wrong `regs_o` lane. Faults in the hold and shadow logic only become visible at a window edge. A stale or lost update shows on `regs_o` a few cycles after chip select falls. A shadow that changes during a window shows in the next read byte that touches addresses 0–6.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 16;
  localparam int NUM_TIME = 7;
  localparam int ADR_RSV  = 13;
  localparam int ADR_CTLA = 14;
  localparam int ADR_CTLB = 15;
  localparam int BIT_OSC  = 4;
  localparam int BIT_H24  = 5;

  // mode field = command bits 3:2; bit 0 of it means read, bit 1 means single
  typedef enum logic [1:0] {
    ACC_BWR = 2'b00,
    ACC_BRD = 2'b01,
    ACC_SWR = 2'b10,
    ACC_SRD = 2'b11
  } acc_mode_t;

  typedef enum logic [1:0] {
    PH_CMD  = 2'b00,
    PH_DATA = 2'b01,
    PH_DONE = 2'b10
  } phase_t;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= dout;
  end

  assign rise = dout & ~prev;
  assign fall = ~dout & prev;
endmodule

// File: rtl/rtc_spi_shift.sv
module rtc_spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] bitcnt;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      miso      <= 1'b0;
    end else if (!active) begin
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
      miso      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sck_fall) begin
        rx_sh  <= {rx_sh[DW-2:0], mosi_s};
        bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
        if (bitcnt == LAST) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[DW-2:0], mosi_s};
        end
      end
      if (sck_rise) begin
        miso  <= tx_sh[DW-1];
        tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
      if (tx_load) tx_sh <= tx_data;
    end
  end

  AST_BYTE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !byte_done); // R2
endmodule

// File: rtl/rtc_spi_cmd.sv
module rtc_spi_cmd
  import rtc_spi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          tx_load,
  output logic [DW-1:0] tx_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          quiet
);
  phase_t        phase;
  acc_mode_t     mode;
  logic [AW-1:0] addr;

  logic [AW-1:0] cmd_addr;
  acc_mode_t     cmd_mode;
  logic          cmd_ok;

  assign cmd_addr = rx_byte[DW-1 -: AW];
  assign cmd_mode = acc_mode_t'(rx_byte[3:2]);
  assign cmd_ok   = (rx_byte[1:0] == 2'b00);

  always_comb begin
    rd_addr = (phase == PH_CMD) ? cmd_addr : addr + 1'b1;
    tx_data = rd_data;
    tx_load = byte_done &&
              ((phase == PH_CMD && cmd_ok && cmd_mode[0]) ||
               (phase == PH_DATA && mode == ACC_BRD));
    wr_en   = byte_done && phase == PH_DATA && !mode[0];
    wr_addr = addr;
    wr_data = rx_byte;
    quiet   = (phase == PH_CMD) || (phase == PH_DATA && !mode[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      mode  <= ACC_BWR;
      addr  <= '0;
    end else if (!active) begin
      phase <= PH_CMD;
      mode  <= ACC_BWR;
      addr  <= '0;
    end else if (byte_done) begin
      unique case (phase)
        PH_CMD: begin
          addr  <= cmd_addr;
          mode  <= cmd_mode;
          phase <= cmd_ok ? PH_DATA : PH_DONE;
        end
        PH_DATA: begin
          if (mode[1]) phase <= PH_DONE;
          else         addr  <= addr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> (!wr_en && !tx_load)); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && byte_done && phase == PH_DATA && !mode[1] && addr == '1) |=> (addr == '0)); // R4
endmodule

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile
  import rtc_spi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREG  = 16,
  parameter int NTIME = 7,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                win_open,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic                upd_valid,
  output logic                upd_ready,
  input  logic [NTIME*DW-1:0] upd_time,
  input  logic                osc_fail,
  output logic [NREG*DW-1:0]  regs_flat
);
  localparam int TW = $clog2(NTIME);
  localparam logic [AW-1:0] TIME_END = AW'(NTIME);
  localparam logic [AW-1:0] RSV_ADR  = AW'(ADR_RSV);
  localparam int CTLB = ADR_CTLB;

  logic [NREG-1:0][DW-1:0]  regs;
  logic [NTIME-1:0][DW-1:0] shadow;
  logic [NTIME-1:0][DW-1:0] hold;
  logic                     held_v;
  logic                     time_wr;

  assign upd_ready = !held_v;
  assign regs_flat = regs;
  assign time_wr   = wr_en && (wr_addr < TIME_END);

  always_comb begin
    if (rd_addr < TIME_END)     rd_data = shadow[rd_addr[TW-1:0]];
    else if (rd_addr == RSV_ADR) rd_data = '0;
    else                         rd_data = regs[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      hold   <= '0;
    end else begin
      if (upd_valid && upd_ready) begin
        held_v <= 1'b1;
        hold   <= upd_time;
      end else if (held_v && !active) begin
        held_v <= 1'b0;
      end
      if (time_wr) held_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (win_open) begin
      for (int i = 0; i < NTIME; i++) shadow[i] <= regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
      regs[CTLB][BIT_OSC] <= 1'b1;
    end else begin
      if (held_v && !active) begin
        for (int i = 0; i < NTIME; i++) regs[i] <= hold[i];
      end
      if (wr_en && wr_addr != RSV_ADR) regs[wr_addr] <= wr_data;
      if (osc_fail) regs[CTLB][BIT_OSC] <= 1'b1;
    end
  end

  AST_HOLD_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (active && held_v && !time_wr) |=> held_v); // R7
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !win_open) |=> $stable(shadow)); // R6
  AST_OSC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> regs[CTLB][BIT_OSC]); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs[ADR_RSV] == '0); // R10
endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
  import rtc_spi_pkg::*;
#(
  parameter int DW    = REG_W,
  parameter int NREG  = NUM_REGS,
  parameter int NTIME = NUM_TIME,
  parameter int SYNC  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_cs,
  input  logic                spi_sck,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic                upd_valid,
  output logic                upd_ready,
  input  logic [NTIME*DW-1:0] upd_time,
  input  logic                osc_fail,
  output logic [NREG*DW-1:0]  regs_o,
  output logic                mode_24h
);
  localparam int AW = $clog2(NREG);

  logic [2:0]    pin_s, pin_r, pin_f;
  logic          cs_s, sck_r, sck_f, mosi_s, cs_r;
  logic          byte_done, tx_load, wr_en, quiet;
  logic [DW-1:0] rx_byte, tx_data, wr_data, rd_data;
  logic [AW-1:0] rd_addr, wr_addr;

  rtc_spi_sync #(.STAGES(SYNC), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_cs, spi_sck, spi_mosi}),
    .dout(pin_s), .rise(pin_r), .fall(pin_f)
  );

  assign cs_s   = pin_s[2];
  assign cs_r   = pin_r[2];
  assign sck_r  = pin_r[1];
  assign sck_f  = pin_f[1];
  assign mosi_s = pin_s[0];

  rtc_spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(cs_s),
    .sck_rise(sck_r), .sck_fall(sck_f), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_data(tx_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  rtc_spi_cmd #(.DW(DW), .AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .active(cs_s),
    .byte_done(byte_done), .rx_byte(rx_byte), .rd_data(rd_data),
    .rd_addr(rd_addr), .tx_load(tx_load), .tx_data(tx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .quiet(quiet)
  );

  rtc_spi_regfile #(.DW(DW), .NREG(NREG), .NTIME(NTIME), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .active(cs_s), .win_open(cs_r),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_time(upd_time),
    .osc_fail(osc_fail), .regs_flat(regs_o)
  );

  assign mode_24h = regs_o[ADR_CTLA*DW + BIT_H24];

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !spi_miso); // R5
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cs_s); // R1
endmodule

// File: tb/tb_rtc_spi_regif.sv
module tb_rtc_spi_regif;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         spi_cs = 1'b0, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic         spi_miso;
  logic         upd_valid = 1'b0;
  logic         upd_ready;
  logic [55:0]  upd_time = '0;
  logic         osc_fail = 1'b0;
  logic [127:0] regs_o;
  logic         mode_24h;

  int checks = 0;
  int errors = 0;

  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic [7:0] exp_rx [16];
  logic [7:0] m [16];
  logic [7:0] snap [7];

  always #5 clk = ~clk;

  rtc_spi_regif dut (
    .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_time(upd_time), .osc_fail(osc_fail),
    .regs_o(regs_o), .mode_24h(mode_24h)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[8*i +: 8] = m[i];
    return f;
  endfunction

  function automatic logic [7:0] rdv(input logic [3:0] a);
    if (a < 7) return snap[a];
    if (a == 13) return 8'h00;
    return m[a];
  endfunction

  // expected behaviour from R1, R3, R4, R6, R7, R8, R10
  task automatic model_txn(input int nb, input bit push, input logic [55:0] uval);
    logic [3:0] a;
    logic [3:0] md;
    bit held;
    held = push;
    for (int i = 0; i < 7; i++) snap[i] = m[i];
    for (int k = 0; k < 16; k++) exp_rx[k] = 8'h00;
    a  = tx_b[0][7:4];
    md = tx_b[0][3:0];
    if (md == 4'h8 || md == 4'hC || md == 4'h0 || md == 4'h4) begin
      for (int k = 1; k < nb; k++) begin
        if (md[3] && k > 1) break;
        if (md[2]) exp_rx[k] = rdv(a);
        else begin
          if (a != 13) m[a] = tx_b[k];
          if (a < 7) held = 0;
        end
        if (!md[3]) a = a + 1'b1;
      end
    end
    if (held) for (int i = 0; i < 7; i++) m[i] = uval[8*i +: 8];
  endtask

  task automatic spi_txn(input int nb, input bit push, input logic [55:0] uval);
    @(negedge clk) spi_cs = 1'b1;
    repeat (4) @(negedge clk);
    if (push) begin
      upd_valid = 1'b1;
      upd_time  = uval;
      @(negedge clk) upd_valid = 1'b0;
      @(negedge clk);
      chk("R7 ready low while update held", {127'd0, upd_ready}, 128'd0);
    end
    for (int k = 0; k < nb; k++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_sck  = 1'b1;
        spi_mosi = tx_b[k][b];
        repeat (8) @(negedge clk);
        rx_b[k][b] = spi_miso;
        spi_sck = 1'b0;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    spi_cs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_txn(input string tag, input int nb, input bit push, input logic [55:0] uval);
    model_txn(nb, push, uval);
    spi_txn(nb, push, uval);
    chk({tag, " R5 command byte MISO"}, {120'd0, rx_b[0]}, 128'd0);
    for (int k = 1; k < nb; k++) chk({tag, " R2 data byte"}, {120'd0, rx_b[k]}, {120'd0, exp_rx[k]});
    chk({tag, " R7 registers after window"}, regs_o, model_flat());
    chk({tag, " R11 mode flag"}, {127'd0, mode_24h}, {127'd0, m[14][5]});
    chk({tag, " R7 ready after window"}, {127'd0, upd_ready}, 128'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20250);
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    m[15] = 8'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset registers", regs_o, model_flat());
    chk("R9 reset ready", {127'd0, upd_ready}, 128'd1);
    chk("R9 reset miso", {127'd0, spi_miso}, 128'd0);

    // R1 single write then single read of hours
    tx_b[0] = 8'h28; tx_b[1] = 8'h37;
    run_txn("R1 single write", 2, 0, '0);
    tx_b[0] = 8'h2C; tx_b[1] = 8'h00;
    run_txn("R1 single read", 2, 0, '0);

    // R4 burst write across the wrap, R10 clear flag, R11 set 24h
    tx_b[0] = 8'hE0; tx_b[1] = 8'h20; tx_b[2] = 8'h00; tx_b[3] = 8'h45; tx_b[4] = 8'h12;
    run_txn("R4 burst write wrap", 5, 0, '0);
    chk("R10 flag cleared", {127'd0, regs_o[124]}, 128'd0);

    // R2 R4 burst read of the time block and wrap from 15
    tx_b[0] = 8'h04;
    for (int k = 1; k < 9; k++) tx_b[k] = 8'hFF;
    run_txn("R4 burst read time", 9, 0, '0);
    tx_b[0] = 8'hD4;
    run_txn("R4 burst read wrap", 6, 0, '0);

    // R6 R7 update held while a burst read runs
    tx_b[0] = 8'h04;
    run_txn("R6 snapshot with held update", 8, 1, 56'h23_11_05_03_09_30_59);

    // R8 time write discards the held update
    tx_b[0] = 8'h30; tx_b[1] = 8'h06;
    run_txn("R8 discard on time write", 2, 1, 56'h24_12_31_00_23_59_58);

    // R7 update held during a control write is applied
    tx_b[0] = 8'h78; tx_b[1] = 8'h5A;
    run_txn("R7 apply after window", 2, 1, 56'h25_01_15_02_10_20_30);

    // R3 extra bytes after a single access; R1 invalid nibble; R10 reserved
    tx_b[0] = 8'h98; tx_b[1] = 8'h11; tx_b[2] = 8'h22; tx_b[3] = 8'h33;
    run_txn("R3 single write extra", 4, 0, '0);
    tx_b[0] = 8'h9C;
    run_txn("R3 single read extra", 4, 0, '0);
    tx_b[0] = 8'h29; tx_b[1] = 8'hAA; tx_b[2] = 8'hBB;
    run_txn("R1 invalid command", 3, 0, '0);
    tx_b[0] = 8'hD8; tx_b[1] = 8'h77;
    run_txn("R10 reserved write", 2, 0, '0);

    // R10 oscillator flag pulse
    @(negedge clk) osc_fail = 1'b1;
    @(negedge clk) osc_fail = 1'b0;
    @(negedge clk);
    m[15][4] = 1'b1;
    chk("R10 flag set by pulse", regs_o, model_flat());

    // random traffic
    for (int t = 0; t < 40; t++) begin
      int choice, nb;
      bit push;
      logic [3:0] low;
      choice = $urandom % 8;
      case (choice)
        0, 1: low = 4'h8;
        2, 3: low = 4'hC;
        4, 5: low = 4'h0;
        6:    low = 4'h4;
        default: low = {2'($urandom % 4), 2'b01};
      endcase
      tx_b[0] = {4'($urandom % 16), low};
      nb = 1 + ($urandom % 6);
      for (int k = 1; k < 16; k++) tx_b[k] = 8'($urandom);
      push = (($urandom % 3) == 0);
      run_txn("R1 R4 random", nb, push, {$urandom, 24'($urandom)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule